// File: doc/BRIEF.md
# Read-Side FIFO Output Stage with Selectable Fall-Through Timing

This block sits between a FIFO's storage array and its consumer. It owns the output data register and the two status flags. It also gates the write strobe against the storage's full indication. At master reset it captures a timing mode, and that mode stays fixed until the next master reset.

In standard mode, a word moves from storage to the output only when read enable is high on a clock edge. The flags then mean "storage empty" and "storage full". In fall-through mode, the stage fetches the head word by itself whenever its output register is vacant. The flags then mean "output holds a valid word" and "no room for another write". Because the output register holds one word, the FIFO as a whole takes one word more than the storage depth in this mode. Both flags are active-low in both modes.

A partial reset empties the stage but keeps the mode. The storage array and any offset logic live outside this block. The storage is expected to present its head word combinationally, together with empty and full indications.

Top module: `fwst_out_stage`

## Requirements
- R1: The timing mode is loaded from `fwft_sel` (0 = standard, 1 = fall-through) only while `mst_rst_n` is low. Changes on `fwft_sel` at any other time have no effect on behaviour.
- R2: In standard mode, `rd_en` high on a clock edge while `mem_empty` is low pulses `mem_pop` in that cycle. After that edge, `dout` equals the storage head word, and successive reads return words in write order.
- R3: In standard mode, `rd_en` while `mem_empty` is high leaves `dout` unchanged and does not pulse `mem_pop`.
- R4: In fall-through mode, when the output register is vacant and storage is not empty, the head word is loaded into `dout` on the next edge without any `rd_en`.
- R5: In fall-through mode, `rd_en` while `rdy_n` is low consumes the output word. It also fetches the next word in the same edge if storage is not empty; otherwise `rdy_n` rises and `dout` holds.
- R6: In fall-through mode, depth+1 writes with no reads make `room_n` go high, and the first word is already on `dout`.
- R7: `mem_push` is high only when `wr_en` is high, `mem_full` is low, and both resets are inactive. A write attempted while storage is full is dropped.
- R8: Flag encoding in standard mode: `rdy_n` low means storage empty, and `room_n` low means storage full. In fall-through mode: `rdy_n` low means `dout` holds a valid word, and `room_n` high means no room for a write.
- R9: A partial reset (`prt_rst_n` low) keeps the mode and vacates the output register. Afterwards, standard mode shows `rdy_n`=0 and `room_n`=1, and fall-through mode shows `rdy_n`=1 and `room_n`=0.
- R10: After a master reset, `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for read and write sides |
| mst_rst_n | input | 1 | Master reset, active low, synchronous; loads the mode |
| prt_rst_n | input | 1 | Partial reset, active low, synchronous; keeps the mode |
| fwft_sel | input | 1 | Mode request sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request from the producer |
| rd_en | input | 1 | Read request from the consumer |
| mem_empty | input | 1 | Storage holds no word |
| mem_full | input | 1 | Storage holds depth words |
| mem_rd_data | input | W | Storage head word, valid while not empty |
| mem_push | output | 1 | Gated write strobe to storage |
| mem_pop | output | 1 | Removes the head word from storage |
| dout | output | W | Output data register |
| rdy_n | output | 1 | Empty flag (standard) or output-ready flag (fall-through), active low |
| room_n | output | 1 | Full flag (standard) or input-ready flag (fall-through), active low |

## Verification
The same write bursts are run in each mode. Each burst fills the storage and then tries one more write. This shows apart explicit-read loading from automatic loading, and storage-depth capacity from depth+1 capacity. Reads past the last word check that `dout` holds its value and that the flags in each mode report vacancy. The mode pin is toggled after reset, and partial resets are applied in both modes, to show that the mode latch ignores the pin and survives a partial reset.

// File: rtl/fwst_pkg.sv
package fwst_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } fwst_mode_e;
endpackage

// File: rtl/fwst_mode_reg.sv
module fwst_mode_reg
   import fwst_pkg::*;
(
   input  logic       clk,
   input  logic       mst_rst_n,
   input  logic       fwft_sel,
   output fwst_mode_e mode
);
   // Mode is captured only while master reset is held
   always_ff @(posedge clk) begin
      if (!mst_rst_n) mode <= fwft_sel ? MODE_FWFT : MODE_STD;
   end
endmodule

// File: rtl/fwst_out_reg.sv
module fwst_out_reg
   import fwst_pkg::*;
#(
   parameter int  W          = 16,
   parameter bit  CLR_ON_PRT = 1'b1
) (
   input  logic         clk,
   input  logic         mst_rst_n,
   input  logic         prt_rst_n,
   input  fwst_mode_e   mode,
   input  logic         rd_en,
   input  logic         mem_empty,
   input  logic [W-1:0] mem_rd_data,
   output logic [W-1:0] dout,
   output logic         out_valid,
   output logic         mem_pop
);
   logic active;
   logic want;

   assign active = mst_rst_n & prt_rst_n;

   // Standard mode fetches on demand; fall-through also fetches into a vacant register
   always_comb begin
      if (mode == MODE_FWFT) want = rd_en | ~out_valid;
      else                   want = rd_en;
   end

   assign mem_pop = active & want & ~mem_empty;

   always_ff @(posedge clk) begin
      if (!active)      out_valid <= 1'b0;
      else if (mem_pop) out_valid <= 1'b1;
      else if (rd_en)   out_valid <= 1'b0;
   end

   generate
      if (CLR_ON_PRT) begin : g_clr_prt
         always_ff @(posedge clk) begin
            if (!active)      dout <= '0;
            else if (mem_pop) dout <= mem_rd_data;
         end
      end else begin : g_keep_prt
         always_ff @(posedge clk) begin
            if (!mst_rst_n)                dout <= '0;
            else if (prt_rst_n && mem_pop) dout <= mem_rd_data;
         end
      end
   endgenerate
endmodule

// File: rtl/fwst_flag_gen.sv
module fwst_flag_gen
   import fwst_pkg::*;
(
   input  fwst_mode_e mode,
   input  logic       mem_empty,
   input  logic       mem_full,
   input  logic       out_valid,
   output logic       rdy_n,
   output logic       room_n
);
   always_comb begin
      if (mode == MODE_FWFT) begin
         rdy_n  = ~out_valid;
         room_n = mem_full;
      end else begin
         rdy_n  = ~mem_empty;
         room_n = ~mem_full;
      end
   end
endmodule

// File: rtl/fwst_out_stage.sv
module fwst_out_stage
   import fwst_pkg::*;
#(
   parameter int W          = 16,
   parameter bit CLR_ON_PRT = 1'b1
) (
   input  logic         clk,
   input  logic         mst_rst_n,
   input  logic         prt_rst_n,
   input  logic         fwft_sel,
   input  logic         wr_en,
   input  logic         rd_en,
   input  logic         mem_empty,
   input  logic         mem_full,
   input  logic [W-1:0] mem_rd_data,
   output logic         mem_push,
   output logic         mem_pop,
   output logic [W-1:0] dout,
   output logic         rdy_n,
   output logic         room_n
);
   initial begin
      if (W < 1) $error("fwst_out_stage: W must be at least 1");
   end

   fwst_mode_e mode;
   logic       out_valid;

   fwst_mode_reg u_mode (
      .clk       (clk),
      .mst_rst_n (mst_rst_n),
      .fwft_sel  (fwft_sel),
      .mode      (mode)
   );

   fwst_out_reg #(.W(W), .CLR_ON_PRT(CLR_ON_PRT)) u_oreg (
      .clk         (clk),
      .mst_rst_n   (mst_rst_n),
      .prt_rst_n   (prt_rst_n),
      .mode        (mode),
      .rd_en       (rd_en),
      .mem_empty   (mem_empty),
      .mem_rd_data (mem_rd_data),
      .dout        (dout),
      .out_valid   (out_valid),
      .mem_pop     (mem_pop)
   );

   fwst_flag_gen u_flags (
      .mode      (mode),
      .mem_empty (mem_empty),
      .mem_full  (mem_full),
      .out_valid (out_valid),
      .rdy_n     (rdy_n),
      .room_n    (room_n)
   );

   assign mem_push = wr_en & ~mem_full & mst_rst_n & prt_rst_n;
endmodule

// File: rtl/fwst_out_stage_chk.sv
module fwst_out_stage_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         mst_rst_n,
   input logic         prt_rst_n,
   input logic         wr_en,
   input logic         rd_en,
   input logic         mem_empty,
   input logic         mem_full,
   input logic         mem_push,
   input logic         mem_pop,
   input logic [W-1:0] dout,
   input logic         rdy_n,
   input logic         mode_bit
);
   logic live;
   assign live = mst_rst_n & prt_rst_n;

   // R7: write strobe only with request and room
   assert_push_gate_R7: assert property (@(posedge clk) disable iff (!live)
      mem_push |-> (wr_en && !mem_full));

   // R2: never pop an empty storage
   assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!live)
      mem_pop |-> !mem_empty);

   // R3: standard read on empty holds the output
   assert_std_hold_R3: assert property (@(posedge clk) disable iff (!live)
      (!mode_bit && rd_en && mem_empty) |=> $stable(dout));

   // R4: fall-through fetches into a vacant register
   assert_fwft_fetch_R4: assert property (@(posedge clk) disable iff (!live)
      (mode_bit && rdy_n && !mem_empty) |-> mem_pop);

   // R5: fall-through read of a valid word fetches the next
   assert_fwft_next_R5: assert property (@(posedge clk) disable iff (!live)
      (mode_bit && !rdy_n && rd_en && !mem_empty) |-> mem_pop);

   // R1: mode fixed outside master reset
   assert_mode_fixed_R1: assert property (@(posedge clk) disable iff (!mst_rst_n)
      $past(mst_rst_n) |-> $stable(mode_bit));
endmodule

bind fwst_out_stage fwst_out_stage_chk #(.W(W)) u_chk (
   .clk       (clk),
   .mst_rst_n (mst_rst_n),
   .prt_rst_n (prt_rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .mem_empty (mem_empty),
   .mem_full  (mem_full),
   .mem_push  (mem_push),
   .mem_pop   (mem_pop),
   .dout      (dout),
   .rdy_n     (rdy_n),
   .mode_bit  (mode == fwst_pkg::MODE_FWFT)
);

// File: tb/fwst_out_stage_tb.sv
module fwst_out_stage_tb;
   localparam int W     = 16;
   localparam int DEPTH = 4;
   localparam int AW    = $clog2(DEPTH);

   logic         clk = 1'b0;
   logic         mst_rst_n = 1'b0;
   logic         prt_rst_n = 1'b1;
   logic         fwft_sel = 1'b0;
   logic         wr_en = 1'b0;
   logic         rd_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         mem_empty, mem_full, mem_push, mem_pop, rdy_n, room_n;
   logic [W-1:0] mem_rd_data, dout;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   // Storage model for the out-of-block array
   logic [W-1:0] arr [DEPTH];
   logic [AW-1:0] wp, rp;
   int cnt;
   assign mem_empty   = (cnt == 0);
   assign mem_full    = (cnt == DEPTH);
   assign mem_rd_data = arr[rp];

   always_ff @(posedge clk) begin
      if (!mst_rst_n || !prt_rst_n) begin
         wp <= '0; rp <= '0; cnt <= 0;
      end else begin
         if (mem_push) begin arr[wp] <= wr_data; wp <= wp + 1'b1; end
         if (mem_pop) rp <= rp + 1'b1;
         cnt <= cnt + (mem_push ? 1 : 0) - (mem_pop ? 1 : 0);
      end
   end

   fwst_out_stage #(.W(W)) u_dut (
      .clk(clk), .mst_rst_n(mst_rst_n), .prt_rst_n(prt_rst_n), .fwft_sel(fwft_sel),
      .wr_en(wr_en), .rd_en(rd_en), .mem_empty(mem_empty), .mem_full(mem_full),
      .mem_rd_data(mem_rd_data), .mem_push(mem_push), .mem_pop(mem_pop),
      .dout(dout), .rdy_n(rdy_n), .room_n(room_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_mst(input bit m);
      @(negedge clk);
      mst_rst_n = 1'b0; fwft_sel = m; wr_en = 0; rd_en = 0;
      step(); step();
      mst_rst_n = 1'b1;
      step();
   endtask

   task automatic wr(input logic [W-1:0] d);
      wr_data = d; wr_en = 1'b1; step(); wr_en = 1'b0;
   endtask

   task automatic rd();
      rd_en = 1'b1; step(); rd_en = 1'b0;
   endtask

   task automatic t_reset();
      do_mst(1'b0);
      chk(dout == 0, "R10 dout after master reset", dout, 0);
      chk(rdy_n == 0, "R8 std empty flag low after reset", rdy_n, 0);
      chk(room_n == 1, "R8 std full flag high after reset", room_n, 1);
   endtask

   task automatic t_std();
      do_mst(1'b0);
      for (int i = 0; i < DEPTH; i++) wr(16'h100 + 16'(i));
      chk(room_n == 0, "R8 std full flag low at depth", room_n, 0);
      chk(rdy_n == 1, "R8 std empty flag high with data", rdy_n, 1);
      chk(dout == 0, "R2 no data before read", dout, 0);
      wr_data = 16'hDEAD; wr_en = 1'b1;
      #1 chk(mem_push == 0, "R7 push blocked when full", mem_push, 0);
      step(); wr_en = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         rd();
         chk(dout == 16'h100 + 16'(i), "R2 std read order", dout, 16'h100 + i);
      end
      chk(rdy_n == 0, "R8 std empty flag after drain", rdy_n, 0);
      rd_en = 1'b1;
      #1 chk(mem_pop == 0, "R3 no pop on empty read", mem_pop, 0);
      step(); rd_en = 1'b0;
      chk(dout == 16'h103, "R3 dout held on empty read", dout, 16'h103);
   endtask

   task automatic t_mode_pin();
      do_mst(1'b0);
      fwft_sel = 1'b1;
      wr(16'h55);
      step(); step(); step();
      chk(dout == 0, "R1 no auto-load after pin change", dout, 0);
      chk(rdy_n == 1, "R1 flags still standard", rdy_n, 1);
      rd();
      chk(dout == 16'h55, "R1 explicit read still required", dout, 16'h55);
      fwft_sel = 1'b0;
   endtask

   task automatic t_fwft();
      do_mst(1'b1);
      chk(rdy_n == 1, "R8 ready flag high when vacant", rdy_n, 1);
      chk(room_n == 0, "R8 input flag low with room", room_n, 0);
      wr(16'h200);
      chk(rdy_n == 1, "R4 not yet loaded after write edge", rdy_n, 1);
      step();
      chk(dout == 16'h200, "R4 first word falls through", dout, 16'h200);
      chk(rdy_n == 0, "R4 ready flag low after load", rdy_n, 0);
      for (int i = 1; i <= DEPTH; i++) wr(16'h200 + 16'(i));
      step();
      chk(room_n == 1, "R6 input flag high after depth+1 writes", room_n, 1);
      wr_data = 16'hBEEF; wr_en = 1'b1;
      #1 chk(mem_push == 0, "R7 extra write dropped", mem_push, 0);
      step(); wr_en = 1'b0;
      chk(dout == 16'h200, "R6 first word held without reads", dout, 16'h200);
      for (int i = 1; i <= DEPTH; i++) begin
         rd();
         chk(dout == 16'h200 + 16'(i), "R5 read fetches next in order", dout, 16'h200 + i);
      end
      chk(rdy_n == 0, "R5 last word still valid", rdy_n, 0);
      rd();
      chk(rdy_n == 1, "R5 ready flag rises when drained", rdy_n, 1);
      chk(dout == 16'h200 + 16'(DEPTH), "R5 dout holds after drain", dout, 16'h200 + DEPTH);
   endtask

   task automatic t_prt(input bit m);
      do_mst(m);
      wr(16'h300); wr(16'h301); step();
      prt_rst_n = 1'b0; step(); prt_rst_n = 1'b1;
      if (m) begin
         chk(rdy_n == 1, "R9 fwft ready flag high after partial reset", rdy_n, 1);
         chk(room_n == 0, "R9 fwft input flag low after partial reset", room_n, 0);
         wr(16'h3A); step();
         chk(dout == 16'h3A, "R9 fall-through kept across partial reset", dout, 16'h3A);
      end else begin
         chk(rdy_n == 0, "R9 std empty flag low after partial reset", rdy_n, 0);
         chk(room_n == 1, "R9 std full flag high after partial reset", room_n, 1);
         wr(16'h3B); step(); step();
         chk(dout == 0, "R9 standard kept across partial reset", dout, 0);
      end
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_std();
            t_mode_pin();
            t_fwft();
            t_prt(1'b0);
            t_prt(1'b1);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule